// File: doc/BRIEF.md
# Configurable Memory-Mapped I/O Port

This block is a byte-wide port controller that a microcontroller reaches through ordinary bus reads and writes. Every access whose address falls inside a 256-byte page starting at a fixed, page-aligned base is decoded to one of seven per-pin registers. Four of these registers can be written: pin mode, output data, direction and open-drain. Three are read-only views: the synchronised pin levels, the ownership mask from the programmable-logic fabric, and the fabric's macrocell outputs.

Each pin takes its drive value from one of two sources, chosen per pin by the mode register. One source is the output data register. The other is an external address bus, used in address-out mode. Each pin's direction bit and open-drain bit then give its output-enable and level. A pin the fabric claims is released at the port boundary, whatever the registers hold. Reads are registered, so returned data is valid in the cycle after the read strobe.

Top module: `cfgIoPort`

## Requirements
- R1: An access takes effect only when busAddr bits [ADDR_W-1:8] equal those of BASE_ADDR. A write outside that page changes nothing, and a read outside it returns 0.
- R2: The page offsets are 0x00 pin levels, 0x02 mode, 0x04 output data, 0x06 direction, 0x08 open-drain, 0x0A fabric ownership and 0x0C macrocell outputs. Mode, output data, direction and open-drain each read back the last value written.
- R3: After reset, mode, output data, direction and open-drain are all 0. Every padOe bit is 0 and busRdData is 0.
- R4: A read strobe sampled at a clock edge puts its data on busRdData for the following cycle. In a cycle not preceded by a read strobe, busRdData is 0.
- R5: Writes to the read-only offsets (0x00, 0x0A, 0x0C) and to unmapped offsets have no effect. Unmapped offsets, including odd ones, read as 0.
- R6: The pin-level read passes through two flip-flops. A level present on padIn before edge k is returned by a read strobe sampled at edge k+2 or later. A strobe sampled at edge k or k+1 still returns the older level.
- R7: Offset 0x0A returns pldOwned and offset 0x0C returns mcellOut, both as sampled at the read strobe's edge.
- R8: When a pin is not owned and its open-drain bit is 0 (push-pull), padOe follows its direction bit (1 = output) and padOut equals its source bit while enabled.
- R9: A mode bit of 1 (register I/O) makes the pin's source the output-data bit. A mode bit of 0 (address-out) makes the source the matching addrOutSrc bit.
- R10: When a pin's open-drain bit is 1, padOut is 0. The pin is enabled only when its direction bit is 1 and its source bit is 0.
- R11: A pin whose pldOwned bit is 1 has padOe = 0 and padOut = 0, whatever the register contents.
- R12: padOut is 0 on every pin whose padOe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Bus address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWrData | input | PIN_W | Write data |
| busRdData | output | PIN_W | Read data, valid the cycle after busRd |
| padIn | input | PIN_W | Asynchronous pin levels |
| pldOwned | input | PIN_W | Per-pin ownership by the programmable-logic fabric |
| mcellOut | input | PIN_W | Macrocell outputs from the fabric |
| addrOutSrc | input | PIN_W | External address bits driven in address-out mode |
| padOut | output | PIN_W | Pin drive level |
| padOe | output | PIN_W | Pin output-enable |

## Verification
The bench builds the block with PIN_W = 8, ADDR_W = 16 and BASE_ADDR = 0xA500. With these values, an access at the correct offset but in the neighbouring pages (0xA4xx and 0xA6xx) tests the page comparison in isolation. Separately, setting mode bits differently in each nibble mixes register data and address bits within a single byte. The pin-level read is timed strobe by strobe around an input change to pin down both synchroniser stages. Each drive mode is then crossed with a split open-drain mask and a partial ownership mask.

// File: rtl/ioPortPkg.sv
package ioPortPkg;

  // Width of the in-page offset: the register window spans 256 bytes.
  localparam int unsigned WIN_BITS = 8;

  localparam logic [WIN_BITS-1:0] OFF_LEVEL = 8'h00;
  localparam logic [WIN_BITS-1:0] OFF_MODE  = 8'h02;
  localparam logic [WIN_BITS-1:0] OFF_DOUT  = 8'h04;
  localparam logic [WIN_BITS-1:0] OFF_DIR   = 8'h06;
  localparam logic [WIN_BITS-1:0] OFF_ODRN  = 8'h08;
  localparam logic [WIN_BITS-1:0] OFF_OWN   = 8'h0A;
  localparam logic [WIN_BITS-1:0] OFF_MCELL = 8'h0C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_MODE,
    SEL_DOUT,
    SEL_DIR,
    SEL_ODRN,
    SEL_OWN,
    SEL_MCELL
  } rdSel_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic   wrMode;
    logic   wrDout;
    logic   wrDir;
    logic   wrOdrn;
    logic   rdEn;
    rdSel_e rdSel;
  } portStb_t;

endpackage

// File: rtl/ioPortDecode.sv
module ioPortDecode
  import ioPortPkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output portStb_t          stb
);

  localparam int unsigned PAGE_W = ADDR_W - WIN_BITS;

  logic [PAGE_W-1:0]   pageOfAddr;
  logic [PAGE_W-1:0]   pageOfBase;
  logic [WIN_BITS-1:0] offset;
  logic                inWin;
  rdSel_e              hitSel;

  assign pageOfAddr = busAddr[ADDR_W-1:WIN_BITS];
  assign pageOfBase = BASE_ADDR[ADDR_W-1:WIN_BITS];
  assign offset     = busAddr[WIN_BITS-1:0];
  assign inWin      = (pageOfAddr == pageOfBase);

  always_comb begin
    unique case (offset)
      OFF_LEVEL: hitSel = SEL_LEVEL;
      OFF_MODE:  hitSel = SEL_MODE;
      OFF_DOUT:  hitSel = SEL_DOUT;
      OFF_DIR:   hitSel = SEL_DIR;
      OFF_ODRN:  hitSel = SEL_ODRN;
      OFF_OWN:   hitSel = SEL_OWN;
      OFF_MCELL: hitSel = SEL_MCELL;
      default:   hitSel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb.wrMode = busWr && inWin && (hitSel == SEL_MODE);
    stb.wrDout = busWr && inWin && (hitSel == SEL_DOUT);
    stb.wrDir  = busWr && inWin && (hitSel == SEL_DIR);
    stb.wrOdrn = busWr && inWin && (hitSel == SEL_ODRN);
    stb.rdEn   = busRd;
    stb.rdSel  = (busRd && inWin) ? hitSel : SEL_NONE;
  end

  AST_WR_OUTSIDE_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr[ADDR_W-1:WIN_BITS] != BASE_ADDR[ADDR_W-1:WIN_BITS]))
      |-> !(stb.wrMode || stb.wrDout || stb.wrDir || stb.wrOdrn)); // R1

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrMode, stb.wrDout, stb.wrDir, stb.wrOdrn})); // R2

  AST_NO_WR_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |-> !(stb.wrMode || stb.wrDout || stb.wrDir || stb.wrOdrn)); // R5

endmodule

// File: rtl/ioPortData.sv
module ioPortData
  import ioPortPkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStb_t         stb,
  input  logic [PIN_W-1:0] busWrData,
  output logic [PIN_W-1:0] busRdData,
  input  logic [PIN_W-1:0] padIn,
  input  logic [PIN_W-1:0] pldOwned,
  input  logic [PIN_W-1:0] mcellOut,
  input  logic [PIN_W-1:0] addrOutSrc,
  output logic [PIN_W-1:0] padOut,
  output logic [PIN_W-1:0] padOe
);

  logic [PIN_W-1:0] modeReg;
  logic [PIN_W-1:0] doutReg;
  logic [PIN_W-1:0] dirReg;
  logic [PIN_W-1:0] odrnReg;
  logic [PIN_W-1:0] syncA;
  logic [PIN_W-1:0] syncB;
  logic [PIN_W-1:0] rdMux;
  logic [PIN_W-1:0] rdData;

  // Writable registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      doutReg <= '0;
      dirReg  <= '0;
      odrnReg <= '0;
    end else begin
      if (stb.wrMode) modeReg <= busWrData;
      if (stb.wrDout) doutReg <= busWrData;
      if (stb.wrDir)  dirReg  <= busWrData;
      if (stb.wrOdrn) odrnReg <= busWrData;
    end
  end

  // Two-stage synchroniser on the pin levels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  // Read path, registered
  always_comb begin
    unique case (stb.rdSel)
      SEL_LEVEL: rdMux = syncB;
      SEL_MODE:  rdMux = modeReg;
      SEL_DOUT:  rdMux = doutReg;
      SEL_DIR:   rdMux = dirReg;
      SEL_ODRN:  rdMux = odrnReg;
      SEL_OWN:   rdMux = pldOwned;
      SEL_MCELL: rdMux = mcellOut;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= stb.rdEn ? rdMux : '0;
  end

  assign busRdData = rdData;

  // Per-pin drive logic
  for (genvar i = 0; i < PIN_W; i++) begin : gPin
    logic srcBit;
    logic oeBit;
    assign srcBit = modeReg[i] ? doutReg[i] : addrOutSrc[i];
    always_comb begin
      if (pldOwned[i])     oeBit = 1'b0;
      else if (odrnReg[i]) oeBit = dirReg[i] & ~srcBit;
      else                 oeBit = dirReg[i];
    end
    assign padOe[i]  = oeBit;
    assign padOut[i] = oeBit & ~odrnReg[i] & srcBit;
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> (busRdData == '0)); // R4

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrDir |=> $stable(dirReg)); // R5

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrDout |=> $stable(doutReg)); // R5

  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & ~dirReg) == '0)); // R8

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut & odrnReg) == '0)); // R10

  AST_OWNED_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & pldOwned) == '0)); // R11

  AST_OUT_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut & ~padOe) == '0)); // R12

endmodule

// File: rtl/cfgIoPort.sv
module cfgIoPort
  import ioPortPkg::*;
#(
  parameter int unsigned PIN_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [PIN_W-1:0]  busWrData,
  output logic [PIN_W-1:0]  busRdData,
  input  logic [PIN_W-1:0]  padIn,
  input  logic [PIN_W-1:0]  pldOwned,
  input  logic [PIN_W-1:0]  mcellOut,
  input  logic [PIN_W-1:0]  addrOutSrc,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padOe
);

  portStb_t stb;

  ioPortDecode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) uDecode (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .stb     (stb)
  );

  ioPortData #(
    .PIN_W (PIN_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .padIn      (padIn),
    .pldOwned   (pldOwned),
    .mcellOut   (mcellOut),
    .addrOutSrc (addrOutSrc),
    .padOut     (padOut),
    .padOe      (padOe)
  );

endmodule

// File: tb/test_cfgIoPort.sv
module test_cfgIoPort;

  localparam int unsigned PIN_W = 8;
  localparam int unsigned ADDR_W = 16;
  localparam logic [ADDR_W-1:0] BASE = 16'hA500;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWr = 1'b0;
  logic              busRd = 1'b0;
  logic [PIN_W-1:0]  busWrData = '0;
  logic [PIN_W-1:0]  busRdData;
  logic [PIN_W-1:0]  padIn = 8'h3C;
  logic [PIN_W-1:0]  pldOwned = 8'h81;
  logic [PIN_W-1:0]  mcellOut = 8'h5A;
  logic [PIN_W-1:0]  addrOutSrc = 8'h96;
  logic [PIN_W-1:0]  padOut;
  logic [PIN_W-1:0]  padOe;

  int checkCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  cfgIoPort #(
    .PIN_W     (PIN_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE)
  ) i_cfgIoPort (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busRd      (busRd),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .padIn      (padIn),
    .pldOwned   (pldOwned),
    .mcellOut   (mcellOut),
    .addrOutSrc (addrOutSrc),
    .padOut     (padOut),
    .padOe      (padOe)
  );

  typedef struct packed {
    logic       isWr;
    logic [7:0] off;
    logic [7:0] val;   // write data, or expected read data
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h02, 8'hFF, 4'd2},  // R2 mode write
    '{1'b0, 8'h02, 8'hFF, 4'd2},
    '{1'b1, 8'h04, 8'hA5, 4'd2},  // R2 output data
    '{1'b0, 8'h04, 8'hA5, 4'd2},
    '{1'b1, 8'h06, 8'h0F, 4'd2},  // R2 direction
    '{1'b0, 8'h06, 8'h0F, 4'd2},
    '{1'b1, 8'h08, 8'h33, 4'd2},  // R2 open-drain
    '{1'b0, 8'h08, 8'h33, 4'd2},
    '{1'b0, 8'h0A, 8'h81, 4'd7},  // R7 ownership view
    '{1'b0, 8'h0C, 8'h5A, 4'd7},  // R7 macrocell view
    '{1'b0, 8'h00, 8'h3C, 4'd6},  // R6 pin levels
    '{1'b1, 8'h00, 8'hFF, 4'd5},  // R5 read-only offsets
    '{1'b0, 8'h00, 8'h3C, 4'd5},
    '{1'b1, 8'h0A, 8'h00, 4'd5},
    '{1'b0, 8'h0A, 8'h81, 4'd5},
    '{1'b1, 8'h0E, 8'hFF, 4'd5},  // R5 unmapped
    '{1'b0, 8'h0E, 8'h00, 4'd5},
    '{1'b1, 8'h03, 8'h00, 4'd5},  // R5 odd offset next to mode
    '{1'b0, 8'h03, 8'h00, 4'd5},
    '{1'b0, 8'h02, 8'hFF, 4'd5}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Tasks start just after a falling edge and return at the next one.
  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R3 reset state
    check("R3 padOe", padOe, 8'h00);
    check("R3 busRdData", busRdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    busRead(BASE + 16'h02, rd); check("R3 mode", rd, 8'h00);
    busRead(BASE + 16'h04, rd); check("R3 dout", rd, 8'h00);
    busRead(BASE + 16'h06, rd); check("R3 dir", rd, 8'h00);
    busRead(BASE + 16'h08, rd); check("R3 odrn", rd, 8'h00);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) busWrite(BASE + {8'h00, VECS[i].off}, VECS[i].val);
      else begin
        busRead(BASE + {8'h00, VECS[i].off}, rd);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].val);
      end
    end

    // R1 page decode: neighbouring pages
    busWrite(16'hA402, 8'h11);
    busWrite(16'hA602, 8'h22);
    busRead(BASE + 16'h02, rd); check("R1 write outside page", rd, 8'hFF);
    busRead(16'hA602, rd); check("R1 read outside page", rd, 8'h00);

    // R4 data only in the cycle after the strobe
    busRead(BASE + 16'h04, rd); check("R4 read data", rd, 8'hA5);
    @(negedge clk);
    check("R4 idle zero", busRdData, 8'h00);

    // R6 two-stage synchroniser timing
    padIn = 8'hC3;
    busRead(BASE + 16'h00, rd); check("R6 edge k", rd, 8'h3C);
    busRead(BASE + 16'h00, rd); check("R6 edge k+1", rd, 8'h3C);
    busRead(BASE + 16'h00, rd); check("R6 edge k+2", rd, 8'hC3);

    // Pin drive
    pldOwned = 8'h00;
    busWrite(BASE + 16'h02, 8'hFF);
    busWrite(BASE + 16'h04, 8'hA5);
    busWrite(BASE + 16'h06, 8'hFF);
    busWrite(BASE + 16'h08, 8'h00);
    check("R8 push-pull oe", padOe, 8'hFF);
    check("R9 register source", padOut, 8'hA5);
    busWrite(BASE + 16'h02, 8'h00);
    check("R9 address source", padOut, 8'h96);
    busWrite(BASE + 16'h02, 8'hF0);
    check("R9 mixed source", padOut, 8'hA6);
    busWrite(BASE + 16'h06, 8'h0F);
    check("R8 oe follows dir", padOe, 8'h0F);
    check("R12 disabled pins low", padOut, 8'h06);
    busWrite(BASE + 16'h02, 8'hFF);
    busWrite(BASE + 16'h06, 8'hFF);
    busWrite(BASE + 16'h08, 8'hFF);
    check("R10 od oe", padOe, 8'h5A);
    check("R10 od level", padOut, 8'h00);
    busWrite(BASE + 16'h08, 8'h0F);
    check("R10 split oe", padOe, 8'hFA);
    check("R10 split level", padOut, 8'hA0);
    pldOwned = 8'hF0;
    #1;
    check("R11 owned oe", padOe, 8'h0A);
    check("R11 owned level", padOut, 8'h00);

    finishRun();
  end

endmodule